// File: doc/BRIEF.md
# OSD Serial Write Command Decoder

This block takes the byte stream delivered by a serial receiver for an on-screen-display controller and turns it into single memory writes. Each byte is classed by its top bit. A set bit 7 marks a row byte, which picks the target space (character codes, attributes or user-font RAM) and the row. A clear bit 7 marks a column byte, which picks the column and either the explicit mode or the auto-increment mode. Every other byte is data. In explicit mode, data bytes may be separated by new row bytes or by new column bytes. In auto-increment mode, every byte after the column byte is data, and the address moves forward by one location after each data byte.

Bytes enter through a valid/ready stream. Writes leave through a one-entry valid/ready stream. A byte is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high when the output slot is empty or is being drained in that cycle. When the consumer holds `wr_ready` low, the pending write stays frozen and input stops. The single-cycle pulses `pkt_start` and `pkt_end` mark packet boundaries. The bench raises them only together with an accepted byte. The block also holds the panel-mode flag, which is kept in one attribute location and can only be changed by writing a key pattern.

Top module: `osd_cmd_decoder`

## Requirements
- R1: A byte with bit 7 set is a row byte when the decoder expects an address. Bit 6 set selects user-font space (`wr_space`=2), with the row taken from bits 2..0. Otherwise bit 5 selects attribute space (`wr_space`=1) or character-code space (`wr_space`=0), with the row taken from bits 4..0. Space code 3 never appears.
- R2: A byte with bit 7 clear that follows a row byte, or follows explicit-mode data, is a column byte. The column is taken from bits 5..0 in font space and from bits 4..0 otherwise. Bit 6 set enters auto-increment mode. Bit 6 clear expects exactly one data byte.
- R3: After an explicit data byte, the decoder accepts either a row byte (the full row/column/data form) or a column byte (the same row with a new column). Both may be mixed freely within one packet.
- R4: In auto-increment mode, every byte is data whatever its bit 7 value, until a packet boundary occurs.
- R5: In auto-increment mode, each data byte is written at the current location and the column then advances. The last column is 30 in character space, 29 in attribute rows 0..14, 31 in other attribute rows, and 35 in font space. After the last column, the column becomes 0 and the row advances, modulo 8 in font space and modulo 32 otherwise.
- R6: In character space, `wr_data[8]` equals bit 5 of the most recent column byte given in character space. This value persists across data bytes. In other spaces, `wr_data[8]` is 0.
- R7: Writes outside the valid locations are dropped. Valid locations are: character rows 0..14 with columns 0..30; attribute rows 0..14 with columns 0..29; attribute row 15 with columns 0..22; attribute row 16 with columns 0, 1, 2 and 4; font rows 0..7 with columns 0..35.
- R8: A write to attribute row 16, column 4 sets `panel_mode` to 1 only when data bit 7 is 1 and bits 5..0 are 010101. It clears `panel_mode` to 0 only when data bit 7 is 0 and bits 5..0 are 101010. In every other case `panel_mode` keeps its value. The emitted data carries the resulting mode in bit 7.
- R9: `pkt_start` puts the decoder in the row-expecting state before the byte of that cycle is decoded. `pkt_end` puts it in the row-expecting state after that byte is decoded. In that state, a byte with bit 7 clear is ignored.
- R10: `in_ready` is high exactly when `wr_valid` is low or `wr_ready` is high. A write is held stable while it is stalled. Writes leave in the order of their bytes.
- R11: After reset, `wr_valid` and `panel_mode` are 0, `in_ready` is 1, the latched data bit 8 is 0, and the decoder expects a row byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Decoder can take a byte |
| in_byte | input | 8 | Received byte |
| pkt_start | input | 1 | First byte of a packet |
| pkt_end | input | 1 | Last byte of a packet |
| wr_valid | output | 1 | Write pending |
| wr_ready | input | 1 | Consumer takes the pending write |
| wr_space | output | 2 | 0 character codes, 1 attributes, 2 user font |
| wr_row | output | 5 | Target row |
| wr_col | output | 6 | Target column |
| wr_data | output | 9 | Write data, bit 8 from the column byte |
| panel_mode | output | 1 | Key-guarded panel-mode flag |

## Verification
Two events can fall in the same cycle: a packet boundary and the decoding of the byte that carries it. A data byte with `pkt_end` must still be written. A row byte with `pkt_start` in the middle of an auto-increment stream must be read as a row and not as data. The bench provokes both cases in directed packets and compares the writes that come out with hand-computed locations. A second overlap is a new byte arriving while the output slot is stalled. The random phase combines random boundaries with random `wr_ready`, and a behavioural model checks every cycle.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;
  localparam int BYTE_W     = 8;
  localparam int ROW_W      = 5;
  localparam int COL_W      = 6;
  localparam int DCOL_W     = 5;
  localparam int FROW_W     = 3;
  localparam int KEY_W      = 6;
  localparam int WDATA_W    = BYTE_W + 1;

  localparam logic [ROW_W-1:0] GRID_ROWS  = ROW_W'(15);
  localparam logic [ROW_W-1:0] CTRL_ROW   = ROW_W'(15);
  localparam logic [ROW_W-1:0] EXT_ROW    = ROW_W'(16);
  localparam logic [ROW_W-1:0] FONT_ROWS  = ROW_W'(8);
  localparam logic [COL_W-1:0] CHAR_LAST  = COL_W'(30);
  localparam logic [COL_W-1:0] ATTR_LAST  = COL_W'(29);
  localparam logic [COL_W-1:0] SPAN_LAST  = COL_W'(31);
  localparam logic [COL_W-1:0] CTRL_LAST  = COL_W'(22);
  localparam logic [COL_W-1:0] FONT_LAST  = COL_W'(35);
  localparam logic [COL_W-1:0] MODE_COL   = COL_W'(4);
  localparam logic [COL_W-1:0] GAP_COL    = COL_W'(3);
  localparam logic [KEY_W-1:0] KEY_SET    = 6'b010101;
  localparam logic [KEY_W-1:0] KEY_CLR    = 6'b101010;

  typedef enum logic [1:0] {SP_CHAR = 2'd0, SP_ATTR = 2'd1, SP_FONT = 2'd2} space_e;
  typedef enum logic [2:0] {ST_IDLE, ST_COL, ST_DATA, ST_NEXT, ST_AUTO} dec_st_e;

  typedef struct packed {
    space_e             space;
    logic [ROW_W-1:0]   row;
    logic [COL_W-1:0]   col;
    logic [WDATA_W-1:0] data;
  } wr_cmd_t;

  function automatic logic [COL_W-1:0] last_col(space_e sp, logic [ROW_W-1:0] r);
    case (sp)
      SP_CHAR: return CHAR_LAST;
      SP_ATTR: return (r < GRID_ROWS) ? ATTR_LAST : SPAN_LAST;
      default: return FONT_LAST;
    endcase
  endfunction

  function automatic logic loc_ok(space_e sp, logic [ROW_W-1:0] r, logic [COL_W-1:0] c);
    case (sp)
      SP_CHAR: return (r < GRID_ROWS) && (c <= CHAR_LAST);
      SP_ATTR: return ((r < GRID_ROWS) && (c <= ATTR_LAST)) ||
                      ((r == CTRL_ROW) && (c <= CTRL_LAST)) ||
                      ((r == EXT_ROW) && (c <= MODE_COL) && (c != GAP_COL));
      SP_FONT: return (r < FONT_ROWS) && (c <= FONT_LAST);
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/osd_cmd_fsm.sv
module osd_cmd_fsm
  import osd_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              pkt_start,
  input  logic              pkt_end,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              emit,
  output space_e            space_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              hi_bit_o
);
  dec_st_e            st_q, st_d, cur_st;
  space_e             sp_q, sp_d;
  logic [ROW_W-1:0]   row_q, row_d, row_inc;
  logic [COL_W-1:0]   col_q, col_d;
  logic               d8_q, d8_d;
  logic [FROW_W-1:0]  frow_inc;
  logic               b7, b6, b5;

  assign b7 = byte_i[BYTE_W-1];
  assign b6 = byte_i[BYTE_W-2];
  assign b5 = byte_i[BYTE_W-3];
  assign frow_inc = row_q[FROW_W-1:0] + FROW_W'(1);
  assign row_inc  = (sp_q == SP_FONT) ? ROW_W'(frow_inc) : row_q + ROW_W'(1);

  always_comb begin
    cur_st = pkt_start ? ST_IDLE : st_q;
    st_d   = cur_st;
    sp_d   = sp_q;
    row_d  = row_q;
    col_d  = col_q;
    d8_d   = d8_q;
    emit   = 1'b0;
    if (take) begin
      case (cur_st)
        ST_DATA: begin
          emit = 1'b1;
          st_d = ST_NEXT;
        end
        ST_AUTO: begin
          emit = 1'b1;
          if (col_q >= last_col(sp_q, row_q)) begin
            col_d = '0;
            row_d = row_inc;
          end else begin
            col_d = col_q + COL_W'(1);
          end
        end
        default: begin
          if (b7) begin
            sp_d  = b6 ? SP_FONT : (b5 ? SP_ATTR : SP_CHAR);
            row_d = b6 ? ROW_W'(byte_i[FROW_W-1:0]) : byte_i[ROW_W-1:0];
            st_d  = ST_COL;
          end else if (cur_st != ST_IDLE) begin
            col_d = (sp_q == SP_FONT) ? byte_i[COL_W-1:0] : COL_W'(byte_i[DCOL_W-1:0]);
            if (sp_q == SP_CHAR) d8_d = b5;
            st_d  = b6 ? ST_AUTO : ST_DATA;
          end
        end
      endcase
    end
    if (pkt_end) st_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sp_q  <= SP_CHAR;
      row_q <= '0;
      col_q <= '0;
      d8_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      sp_q  <= sp_d;
      row_q <= row_d;
      col_q <= col_d;
      d8_q  <= d8_d;
    end
  end

  assign space_o  = sp_q;
  assign row_o    = row_q;
  assign col_o    = col_q;
  assign hi_bit_o = d8_q;
endmodule

// File: rtl/osd_loc_filter.sv
module osd_loc_filter
  import osd_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               emit,
  input  space_e             space_i,
  input  logic [ROW_W-1:0]   row_i,
  input  logic [COL_W-1:0]   col_i,
  input  logic               hi_bit_i,
  input  logic [BYTE_W-1:0]  data_i,
  output logic               wr_ok,
  output logic [WDATA_W-1:0] wr_data,
  output logic               mode_o
);
  logic mode_q, mode_nx, mode_loc, want_set, want_clr;

  assign mode_loc = (space_i == SP_ATTR) && (row_i == EXT_ROW) && (col_i == MODE_COL);
  assign want_set = data_i[BYTE_W-1]  && (data_i[KEY_W-1:0] == KEY_SET);
  assign want_clr = !data_i[BYTE_W-1] && (data_i[KEY_W-1:0] == KEY_CLR);
  assign mode_nx  = want_set ? 1'b1 : (want_clr ? 1'b0 : mode_q);
  assign wr_ok    = emit && loc_ok(space_i, row_i, col_i);

  always_comb begin
    if (mode_loc)                wr_data = {1'b0, mode_nx, data_i[BYTE_W-2:0]};
    else if (space_i == SP_CHAR) wr_data = {hi_bit_i, data_i};
    else                         wr_data = {1'b0, data_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                mode_q <= 1'b0;
    else if (wr_ok && mode_loc) mode_q <= mode_nx;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/osd_wr_stage.sv
module osd_wr_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] payload_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] payload_o,
  output logic         free_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o   <= 1'b0;
      payload_o <= '0;
    end else if (load) begin
      valid_o   <= 1'b1;
      payload_o <= payload_i;
    end else if (ready_i) begin
      valid_o   <= 1'b0;
    end
  end

  assign free_o = !valid_o || ready_i;
endmodule

// File: rtl/osd_cmd_decoder.sv
module osd_cmd_decoder
  import osd_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [BYTE_W-1:0]  in_byte,
  input  logic               pkt_start,
  input  logic               pkt_end,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [1:0]         wr_space,
  output logic [ROW_W-1:0]   wr_row,
  output logic [COL_W-1:0]   wr_col,
  output logic [WDATA_W-1:0] wr_data,
  output logic               panel_mode
);
  localparam int CMD_W = $bits(wr_cmd_t);

  logic               take, emit, hi_bit, wr_ok;
  space_e             cur_sp;
  logic [ROW_W-1:0]   cur_row;
  logic [COL_W-1:0]   cur_col;
  logic [WDATA_W-1:0] flt_data;
  wr_cmd_t            cmd_in, cmd_out;
  logic [CMD_W-1:0]   cmd_q;

  assign take = in_valid && in_ready;

  osd_cmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .take(take), .pkt_start(pkt_start), .pkt_end(pkt_end),
    .byte_i(in_byte), .emit(emit), .space_o(cur_sp), .row_o(cur_row), .col_o(cur_col),
    .hi_bit_o(hi_bit)
  );

  osd_loc_filter u_flt (
    .clk(clk), .rst_n(rst_n), .emit(emit), .space_i(cur_sp), .row_i(cur_row),
    .col_i(cur_col), .hi_bit_i(hi_bit), .data_i(in_byte), .wr_ok(wr_ok),
    .wr_data(flt_data), .mode_o(panel_mode)
  );

  assign cmd_in = '{space: cur_sp, row: cur_row, col: cur_col, data: flt_data};

  osd_wr_stage #(.W(CMD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(wr_ok), .payload_i(cmd_in), .ready_i(wr_ready),
    .valid_o(wr_valid), .payload_o(cmd_q), .free_o(in_ready)
  );

  assign cmd_out  = wr_cmd_t'(cmd_q);
  assign wr_space = cmd_out.space;
  assign wr_row   = cmd_out.row;
  assign wr_col   = cmd_out.col;
  assign wr_data  = cmd_out.data;
endmodule

// File: rtl/osd_cmd_decoder_chk.sv
module osd_cmd_decoder_chk
  import osd_cmd_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [BYTE_W-1:0]  in_byte,
  input logic               pkt_start,
  input logic               pkt_end,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic [1:0]         wr_space,
  input logic [ROW_W-1:0]   wr_row,
  input logic [COL_W-1:0]   wr_col,
  input logic [WDATA_W-1:0] wr_data,
  input logic               panel_mode
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable({wr_space, wr_row, wr_col, wr_data})); // R10
  AST_WRITE_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(in_valid && in_ready)); // R10
  AST_SPACE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_space != 2'd3); // R1
  AST_CHAR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_space == 2'd0 |-> wr_row < GRID_ROWS && wr_col <= CHAR_LAST); // R7
  AST_FONT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_space == 2'd2 |-> wr_row < FONT_ROWS && wr_col <= FONT_LAST); // R7
  AST_HIBIT_CHAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_space != 2'd0 |-> !wr_data[WDATA_W-1]); // R6
  AST_MODE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    panel_mode != $past(panel_mode) |-> wr_valid && wr_space == 2'd1 && wr_row == EXT_ROW
      && wr_col == MODE_COL && wr_data[BYTE_W-1] == panel_mode); // R8
  AST_MODE_SET_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(panel_mode) |-> wr_data[KEY_W-1:0] == KEY_SET); // R8
  AST_MODE_CLR_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(panel_mode) |-> wr_data[KEY_W-1:0] == KEY_CLR); // R8
endmodule

bind osd_cmd_decoder osd_cmd_decoder_chk u_chk (.*);

// File: tb/tb_osd_cmd_decoder.sv
`timescale 1ns/1ps
module tb_osd_cmd_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic pkt_start = 1'b0, pkt_end = 1'b0;
  logic wr_ready = 1'b1;
  logic in_ready, wr_valid, panel_mode;
  logic [1:0] wr_space;
  logic [4:0] wr_row;
  logic [5:0] wr_col;
  logic [8:0] wr_data;

  always #2.5 clk = ~clk;

  osd_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .pkt_start(pkt_start), .pkt_end(pkt_end), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_space(wr_space), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
    .panel_mode(panel_mode)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  bit stall_en = 0;
  logic [15:0] lfsr = 16'hACE1;
  string cur_req = "R11";
  logic [21:0] q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_st = 0, m_sp = 0, m_row = 0, m_col = 0, m_d8 = 0, m_mode = 0, m_v = 0;
  logic [21:0] m_out = '0;

  function automatic bit ref_loc(int sp, int r, int c);
    if (sp == 0) return r < 15 && c <= 30;
    if (sp == 1) return (r < 15 && c <= 29) || (r == 15 && c <= 22) || (r == 16 && c <= 4 && c != 3);
    if (sp == 2) return r < 8 && c <= 35;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_sp = 0; m_row = 0; m_col = 0; m_d8 = 0; m_mode = 0; m_v = 0;
    end else begin
      bit acc, emitw;
      int s, w_sp, w_row, w_col, lc, d, nm;
      logic [7:0] b;
      acc = in_valid && (m_v == 0 || wr_ready);
      emitw = 0; w_sp = 0; w_row = 0; w_col = 0;
      s = pkt_start ? 0 : m_st;
      b = in_byte;
      if (acc) begin
        if (s == 2 || s == 4) begin
          w_sp = m_sp; w_row = m_row; w_col = m_col; emitw = 1;
          if (s == 2) s = 3;
          else begin
            lc = (m_sp == 0) ? 30 : (m_sp == 1) ? ((m_row < 15) ? 29 : 31) : 35;
            if (m_col >= lc) begin
              m_col = 0;
              m_row = (m_sp == 2) ? (m_row + 1) % 8 : (m_row + 1) % 32;
            end else m_col = m_col + 1;
          end
        end else if (b[7]) begin
          m_sp = b[6] ? 2 : (b[5] ? 1 : 0);
          m_row = b[6] ? int'(b[2:0]) : int'(b[4:0]);
          s = 1;
        end else if (s != 0) begin
          m_col = (m_sp == 2) ? int'(b[5:0]) : int'(b[4:0]);
          if (m_sp == 0) m_d8 = b[5];
          s = b[6] ? 4 : 2;
        end
      end
      if (pkt_end) s = 0;
      m_st = s;
      if (emitw && ref_loc(w_sp, w_row, w_col)) begin
        if (w_sp == 1 && w_row == 16 && w_col == 4) begin
          nm = m_mode;
          if (b[7] && b[5:0] == 6'b010101) nm = 1;
          if (!b[7] && b[5:0] == 6'b101010) nm = 0;
          m_mode = nm;
          d = nm * 128 + int'(b[6:0]);
        end else if (w_sp == 0) d = m_d8 * 256 + int'(b);
        else d = int'(b);
        m_out = {2'(w_sp), 5'(w_row), 6'(w_col), 9'(d)};
        m_v = 1;
      end else if (wr_ready) m_v = 0;
    end
  end

  // ready pattern, per-cycle comparison, capture of consumed writes
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wr_ready = stall_en ? lfsr[0] : 1'b1;
    #1;
    if (rst_n && !finished) begin
      chk(in_ready == (m_v == 0 || wr_ready), {cur_req, " ready"}, in_ready, (m_v == 0 || wr_ready));
      chk(wr_valid == m_v[0], {cur_req, " valid"}, wr_valid, m_v);
      if (m_v != 0)
        chk({wr_space, wr_row, wr_col, wr_data} == m_out, {cur_req, " write"},
            {wr_space, wr_row, wr_col, wr_data}, m_out);
      chk(panel_mode == m_mode[0], {cur_req, " mode"}, panel_mode, m_mode);
      if (wr_valid && wr_ready) q.push_back({wr_space, wr_row, wr_col, wr_data});
    end
  end

  task automatic send(input logic [7:0] b, input bit st = 0, input bit en = 0);
    bit done = 0;
    while (!done) begin
      @(negedge clk);
      in_valid = 1'b1; in_byte = b; pkt_start = 1'b0; pkt_end = 1'b0;
      #1;
      if (in_ready) begin
        pkt_start = st; pkt_end = en; done = 1;
      end
    end
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0; pkt_start = 1'b0; pkt_end = 1'b0;
    stall_en = 0;
    repeat (4) @(posedge clk);
  endtask

  task automatic exp_wr(input string req, input int sp, input int r, input int c, input int d);
    logic [21:0] e, got;
    e = {2'(sp), 5'(r), 6'(c), 9'(d)};
    if (q.size() == 0) chk(0, {req, " missing write"}, 0, e);
    else begin
      got = q.pop_front();
      chk(got == e, req, got, e);
    end
  endtask

  task automatic exp_none(input string req);
    chk(q.size() == 0, {req, " extra writes"}, q.size(), 0);
    q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R11: reset state
    chk(wr_valid == 1'b0, "R11 valid after reset", wr_valid, 0);
    chk(in_ready == 1'b1, "R11 ready after reset", in_ready, 1);
    chk(panel_mode == 1'b0, "R11 mode after reset", panel_mode, 0);

    // R1 R3: full row/column/data form across two spaces
    cur_req = "R1";
    send(8'h82, 1); send(8'h05); send(8'h41); send(8'hA3); send(8'h07); send(8'h12, 0, 1);
    drain();
    exp_wr("R1 char write", 0, 2, 5, 9'h041);
    exp_wr("R1 attr write", 1, 3, 7, 9'h012);
    exp_none("R1");

    // R2 R6: shared row, column bit 5 gives data bit 8
    cur_req = "R6";
    send(8'h81, 1); send(8'h23); send(8'h55); send(8'h04); send(8'h66, 0, 1);
    drain();
    exp_wr("R6 hi bit set", 0, 1, 3, 9'h155);
    exp_wr("R2 hi bit clear", 0, 1, 4, 9'h066);
    exp_none("R2");

    // R3: switch between forms inside one packet
    cur_req = "R3";
    send(8'h84, 1); send(8'h01); send(8'h11); send(8'h02); send(8'h22);
    send(8'hC5); send(8'h20); send(8'h33, 0, 1);
    drain();
    exp_wr("R3 first", 0, 4, 1, 9'h011);
    exp_wr("R3 column form", 0, 4, 2, 9'h022);
    exp_wr("R3 row form font", 2, 5, 32, 9'h033);
    exp_none("R3");

    // R4 R5 R6: auto stream in character space, row-like bytes are data
    cur_req = "R4";
    send(8'h81, 1); send(8'h7C); send(8'h01); send(8'h9A); send(8'hC3); send(8'h04, 0, 1);
    drain();
    exp_wr("R4 auto 0", 0, 1, 28, 9'h101);
    exp_wr("R4 auto bit7 data", 0, 1, 29, 9'h19A);
    exp_wr("R4 auto last col", 0, 1, 30, 9'h1C3);
    exp_wr("R5 char wrap", 0, 2, 0, 9'h104);
    exp_none("R4");

    // R5: font row wraps modulo 8, attribute row 14 ends at 29
    cur_req = "R5";
    send(8'hC7, 1); send(8'h62); send(8'hAA); send(8'hBB); send(8'hCC, 0, 1);
    send(8'hAE, 1); send(8'h5D); send(8'h01); send(8'h02, 0, 1);
    drain();
    exp_wr("R5 font 34", 2, 7, 34, 9'h0AA);
    exp_wr("R5 font 35", 2, 7, 35, 9'h0BB);
    exp_wr("R5 font row wrap", 2, 0, 0, 9'h0CC);
    exp_wr("R5 attr 29", 1, 14, 29, 9'h001);
    exp_wr("R5 attr wrap", 1, 15, 0, 9'h002);
    exp_none("R5");

    // R7: reserved locations dropped
    cur_req = "R7";
    send(8'h8F, 1); send(8'h00); send(8'h77);
    send(8'hAF); send(8'h17); send(8'h78);
    send(8'hB0); send(8'h03); send(8'h79);
    send(8'hC2); send(8'h24); send(8'h7A);
    send(8'hAF); send(8'h16); send(8'h7B, 0, 1);
    drain();
    exp_wr("R7 only valid write", 1, 15, 22, 9'h07B);
    exp_none("R7");

    // R8: key-guarded mode location
    cur_req = "R8";
    send(8'hB0, 1); send(8'h04); send(8'h95);
    drain();
    chk(panel_mode == 1'b1, "R8 set with key", panel_mode, 1);
    send(8'hB0, 1); send(8'h04); send(8'h2A);
    send(8'h04); send(8'h8A);
    send(8'h04); send(8'h15, 0, 1);
    drain();
    chk(panel_mode == 1'b0, "R8 no change without key", panel_mode, 0);
    send(8'hB0, 1); send(8'h04); send(8'h95); send(8'h04); send(8'h00, 0, 1);
    drain();
    chk(panel_mode == 1'b1, "R8 kept after bad clear", panel_mode, 1);
    exp_wr("R8 set", 1, 16, 4, 9'h095);
    exp_wr("R8 clear", 1, 16, 4, 9'h02A);
    exp_wr("R8 bad set key", 1, 16, 4, 9'h00A);
    exp_wr("R8 bad clear key", 1, 16, 4, 9'h015);
    exp_wr("R8 set again", 1, 16, 4, 9'h095);
    exp_wr("R8 held", 1, 16, 4, 9'h080);
    exp_none("R8");

    // R9: boundaries coinciding with bytes
    cur_req = "R9";
    send(8'h83, 1); send(8'h05); send(8'h44, 0, 1);
    send(8'h06); send(8'h45);
    send(8'h83); send(8'h07, 0, 1); send(8'h46);
    send(8'h83, 1); send(8'h48); send(8'h50);
    send(8'h84, 1); send(8'h09); send(8'h51, 0, 1);
    drain();
    exp_wr("R9 data with end", 0, 3, 5, 9'h044);
    exp_wr("R9 auto before start", 0, 3, 8, 9'h050);
    exp_wr("R9 row with start", 0, 4, 9, 9'h051);
    exp_none("R9");

    // R10: stalled output keeps order
    cur_req = "R10";
    stall_en = 1;
    send(8'h80, 1); send(8'h40);
    for (int i = 0; i < 40; i++) send(8'(i), 0, i == 39);
    drain();
    for (int i = 0; i < 40; i++) exp_wr("R10 order under stall", 0, (i < 31) ? 0 : 1, (i < 31) ? i : i - 31, i);
    exp_none("R10");

    // random bytes and boundaries, checked by the model each cycle
    cur_req = "R4 R9 R10 random";
    stall_en = 1;
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      send(8'(r), (r[11:8] == 0), (r[15:12] == 0));
    end
    drain();
    q.delete();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule